// File: doc/BRIEF.md
# Virtual Wire Warning Acknowledge Responder

This block sits on the slave side of a sideband handshake whose signals travel as tunneled virtual wires. The master raises one of three warning wires: suspend, host reset, or out-of-band reset. For each warning the block waits until the local upstream request queue for that channel has drained and stayed empty for a programmable quiet window. It then raises the matching acknowledge wire and holds it for as long as the warning stays high. A master that never sees the acknowledge stalls forever, so a high warning must always lead to an acknowledge once the queue goes quiet.

The block also reports local boot progress with two wires. When the local boot-complete strobe arrives and the status wire is still low, it sets a sticky boot-done flag and loads boot-status from the image-integrity input (1 means the image loaded intact). Both flags stay set until a G3 entry event clears them.

Every pin is a plain level or strobe. The block has no data stream, so there is no valid/ready handshake and no back-pressure; serializing the wires into packets is left to a neighbouring block. Inputs are expected to be synchronous to `clk`.

Top module: `vwire_ack_responder`

## Requirements
- R1: While `rst_n` is low, all acknowledge and boot outputs are 0.
- R2: With its warning held high, an acknowledge rises on the clock edge where the channel's queue-empty flag has been sampled high on QUIET_CYCLES consecutive edges after the edge that first sampled the warning high. With the queue already empty and QUIET_CYCLES = 4, this is the 5th edge.
- R3: A queue-empty flag sampled low before the acknowledge is issued restarts the quiet count from zero.
- R4: An acknowledge falls on the first edge that samples its warning low. A warning that falls before its acknowledge is issued produces no acknowledge.
- R5: An acknowledge is never high in the cycle after its warning was sampled low.
- R6: A warning that is already high when reset is released is acknowledged with the R2 timing, counted from the first edge after release. No rising edge is needed.
- R7: The three channels are independent. Bit order across the channels is suspend, host reset, out-of-band. A warning or queue change on one channel does not change another channel's acknowledge.
- R8: A `boot_cpl` strobe sampled while `boot_status` is 0 sets `boot_done` to 1 and loads `boot_status` from `boot_img_ok` on that edge.
- R9: A `boot_cpl` strobe sampled while `boot_status` is 1 changes neither boot output.
- R10: `boot_done` and `boot_status` clear on the edge that samples `g3_entry` high. This takes priority over a simultaneous strobe. Otherwise `boot_done` stays set.
- R11: Once issued, an acknowledge stays high while its warning stays high, even if the queue-empty flag falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sus_warn | input | 1 | Suspend warning level from master |
| hrst_warn | input | 1 | Host reset warning level from master |
| oob_warn | input | 1 | Out-of-band reset warning level from master |
| sus_q_empty | input | 1 | Queue empty flag gating the suspend acknowledge |
| periph_q_empty | input | 1 | Upstream peripheral request queue empty |
| oob_q_empty | input | 1 | Upstream out-of-band request queue empty |
| boot_cpl | input | 1 | One-cycle strobe: local boot finished |
| boot_img_ok | input | 1 | Boot image integrity result, valid with boot_cpl |
| g3_entry | input | 1 | G3 entry event, clears boot flags |
| sus_ack | output | 1 | Suspend acknowledge |
| hrst_ack | output | 1 | Host reset acknowledge |
| oob_ack | output | 1 | Out-of-band reset acknowledge |
| boot_done | output | 1 | Sticky boot-load-done wire |
| boot_status | output | 1 | Boot-load-status wire, 1 = image intact |

## Verification
A channel state machine stuck in its drain state shows up as a missing acknowledge. This becomes visible QUIET_CYCLES+1 edges after the warning, because the expected rise fails to appear. A quiet counter that fails to restart shows up as an acknowledge a few cycles early. A state machine left in its acknowledge state shows up one edge after the warning falls, because the acknowledge stays high. Boot flag faults appear on the edge after the strobe or after G3 entry: a rewritten status, a lost done flag, or flags that survive G3.

// File: rtl/vwr_pkg.sv
package vwr_pkg;
  localparam int NUM_CH  = 3;
  localparam int CH_SUS  = 0;
  localparam int CH_HRST = 1;
  localparam int CH_OOB  = 2;

  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_DRAIN = 2'd1,
    CH_ACK   = 2'd2
  } chan_state_e;
endpackage

// File: rtl/vwr_chan_fsm.sv
module vwr_chan_fsm
  import vwr_pkg::*;
#(
  parameter int QUIET_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic warn,
  input  logic q_empty,
  output logic ack
);
  localparam int CW = $clog2(QUIET_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(QUIET_CYCLES - 1);

  chan_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      CH_IDLE: begin
        cnt_d = '0;
        if (warn) state_d = CH_DRAIN;
      end
      CH_DRAIN: begin
        if (!warn) begin
          state_d = CH_IDLE;
          cnt_d   = '0;
        end else if (q_empty) begin
          if (cnt_q == LAST) begin
            state_d = CH_ACK;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end else begin
          cnt_d = '0;
        end
      end
      CH_ACK: begin
        cnt_d = '0;
        if (!warn) state_d = CH_IDLE;
      end
      default: begin
        state_d = CH_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CH_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign ack = (state_q == CH_ACK);
endmodule

// File: rtl/vwr_boot_flags.sv
module vwr_boot_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic g3_entry,
  input  logic boot_cpl,
  input  logic boot_img_ok,
  output logic boot_done,
  output logic boot_status
);
  logic done_q, stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      stat_q <= 1'b0;
    end else if (g3_entry) begin
      done_q <= 1'b0;
      stat_q <= 1'b0;
    end else if (boot_cpl && !stat_q) begin
      done_q <= 1'b1;
      stat_q <= boot_img_ok;
    end
  end

  assign boot_done   = done_q;
  assign boot_status = stat_q;
endmodule

// File: rtl/vwire_ack_responder.sv
module vwire_ack_responder
  import vwr_pkg::*;
#(
  parameter int QUIET_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sus_warn,
  input  logic hrst_warn,
  input  logic oob_warn,
  input  logic sus_q_empty,
  input  logic periph_q_empty,
  input  logic oob_q_empty,
  input  logic boot_cpl,
  input  logic boot_img_ok,
  input  logic g3_entry,
  output logic sus_ack,
  output logic hrst_ack,
  output logic oob_ack,
  output logic boot_done,
  output logic boot_status
);
  logic [NUM_CH-1:0] warn_v, empty_v, ack_v;

  assign warn_v[CH_SUS]   = sus_warn;
  assign warn_v[CH_HRST]  = hrst_warn;
  assign warn_v[CH_OOB]   = oob_warn;
  assign empty_v[CH_SUS]  = sus_q_empty;
  assign empty_v[CH_HRST] = periph_q_empty;
  assign empty_v[CH_OOB]  = oob_q_empty;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    vwr_chan_fsm #(.QUIET_CYCLES(QUIET_CYCLES)) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .warn    (warn_v[i]),
      .q_empty (empty_v[i]),
      .ack     (ack_v[i])
    );
  end

  assign sus_ack  = ack_v[CH_SUS];
  assign hrst_ack = ack_v[CH_HRST];
  assign oob_ack  = ack_v[CH_OOB];

  vwr_boot_flags u_boot (
    .clk         (clk),
    .rst_n       (rst_n),
    .g3_entry    (g3_entry),
    .boot_cpl    (boot_cpl),
    .boot_img_ok (boot_img_ok),
    .boot_done   (boot_done),
    .boot_status (boot_status)
  );
endmodule

// File: rtl/vwr_checker.sv
module vwr_checker #(
  parameter int QUIET_CYCLES = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] warn,
  input logic [2:0] empty,
  input logic [2:0] ack,
  input logic       g3_entry,
  input logic       boot_done,
  input logic       boot_status
);
  localparam int CW = $clog2(QUIET_CYCLES + 1);

  for (genvar i = 0; i < 3; i++) begin : g_c
    logic [CW-1:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_q <= '0;
      else if (!(warn[i] && empty[i])) run_q <= '0;
      else if (run_q != CW'(QUIET_CYCLES)) run_q <= run_q + 1'b1;
    end

    AST_ACK_NEEDS_WARN: assert property (@(posedge clk) disable iff (!rst_n)
      !warn[i] |=> !ack[i]); // R5
    AST_ACK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack[i] && warn[i]) |=> ack[i]); // R11
    AST_ACK_AFTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack[i]) |-> (run_q >= CW'(QUIET_CYCLES))); // R2
  end

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_done && !g3_entry) |=> boot_done); // R10
  AST_G3_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    g3_entry |=> (!boot_done && !boot_status)); // R10
  AST_STATUS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_status && !g3_entry) |=> boot_status); // R9
  AST_STATUS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    boot_status |-> boot_done); // R8
endmodule

bind vwire_ack_responder vwr_checker #(.QUIET_CYCLES(QUIET_CYCLES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .warn        ({oob_warn, hrst_warn, sus_warn}),
  .empty       ({oob_q_empty, periph_q_empty, sus_q_empty}),
  .ack         ({oob_ack, hrst_ack, sus_ack}),
  .g3_entry    (g3_entry),
  .boot_done   (boot_done),
  .boot_status (boot_status)
);

// File: tb/vwire_ack_responder_test.sv
`timescale 1ns/1ps
module vwire_ack_responder_test;
  logic clk = 1'b0;
  logic rst_n;
  logic sus_warn, hrst_warn, oob_warn;
  logic sus_q_empty, periph_q_empty, oob_q_empty;
  logic boot_cpl, boot_img_ok, g3_entry;
  logic sus_ack, hrst_ack, oob_ack, boot_done, boot_status;

  always #2 clk = ~clk;

  vwire_ack_responder #(.QUIET_CYCLES(4)) uut (
    .clk(clk), .rst_n(rst_n),
    .sus_warn(sus_warn), .hrst_warn(hrst_warn), .oob_warn(oob_warn),
    .sus_q_empty(sus_q_empty), .periph_q_empty(periph_q_empty), .oob_q_empty(oob_q_empty),
    .boot_cpl(boot_cpl), .boot_img_ok(boot_img_ok), .g3_entry(g3_entry),
    .sus_ack(sus_ack), .hrst_ack(hrst_ack), .oob_ack(oob_ack),
    .boot_done(boot_done), .boot_status(boot_status)
  );

  typedef struct {
    int         cyc;
    logic [4:0] val;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Expected outputs {sus_ack, hrst_ack, oob_ack, boot_done, boot_status}
  task automatic expect_at(input int dly, input logic [4:0] val, input string req);
    exp_t e;
    e.cyc = cyc + dly;
    e.val = val;
    e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: samples 1 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      for (int i = exp_q.size() - 1; i >= 0; i--) begin
        if (exp_q[i].cyc == cyc) begin
          logic [4:0] act;
          act = {sus_ack, hrst_ack, oob_ack, boot_done, boot_status};
          checks++;
          if (act !== exp_q[i].val) begin
            errors++;
            $display("FAIL %s cycle %0d actual %b expected %b",
                     exp_q[i].req, cyc, act, exp_q[i].val);
          end
          exp_q.delete(i);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      if (exp_q.size() != 0) begin
        errors += exp_q.size();
        $display("FAIL unchecked expectations %0d actual 0 expected 0", exp_q.size());
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    sus_warn = 1'b1; hrst_warn = 1'b0; oob_warn = 1'b0;
    sus_q_empty = 1'b1; periph_q_empty = 1'b1; oob_q_empty = 1'b1;
    boot_cpl = 1'b0; boot_img_ok = 1'b0; g3_entry = 1'b0;
    step(2);
    expect_at(1, 5'b00000, "R1");
    step(1);
    // R6: suspend warning already high at reset release
    rst_n = 1'b1;
    expect_at(4, 5'b00000, "R6");
    expect_at(5, 5'b10000, "R6");
    step(6);
    sus_warn = 1'b0;
    expect_at(1, 5'b00000, "R4");
    step(2);
    // R2/R3: host reset with busy queue and a glitch in the empty flag
    hrst_warn = 1'b1;
    periph_q_empty = 1'b0;
    step(3);
    periph_q_empty = 1'b1;
    expect_at(4, 5'b00000, "R3");
    step(2);
    periph_q_empty = 1'b0;
    step(1);
    periph_q_empty = 1'b1;
    expect_at(3, 5'b00000, "R3");
    expect_at(4, 5'b01000, "R2");
    step(6);
    // R11 hold while queue refills; R7 second channel independent
    periph_q_empty = 1'b0;
    oob_warn = 1'b1;
    expect_at(2, 5'b01000, "R11");
    expect_at(4, 5'b01000, "R7");
    expect_at(5, 5'b01100, "R7");
    step(6);
    hrst_warn = 1'b0;
    expect_at(1, 5'b00100, "R4");
    step(2);
    oob_warn = 1'b0;
    expect_at(1, 5'b00000, "R4");
    step(2);
    // R4/R5: short warning pulse gets no acknowledge
    sus_warn = 1'b1;
    step(2);
    sus_warn = 1'b0;
    expect_at(1, 5'b00000, "R5");
    expect_at(3, 5'b00000, "R4");
    expect_at(5, 5'b00000, "R4");
    step(6);
    // R8: boot strobe with bad image, then good image
    boot_cpl = 1'b1; boot_img_ok = 1'b0;
    expect_at(1, 5'b00010, "R8");
    step(1);
    boot_cpl = 1'b0;
    step(2);
    boot_cpl = 1'b1; boot_img_ok = 1'b1;
    expect_at(1, 5'b00011, "R8");
    step(1);
    boot_cpl = 1'b0;
    step(2);
    // R9: status already set is not rewritten
    boot_cpl = 1'b1; boot_img_ok = 1'b0;
    expect_at(1, 5'b00011, "R9");
    expect_at(2, 5'b00011, "R9");
    step(1);
    boot_cpl = 1'b0;
    step(3);
    // R10: G3 entry clears, wins over strobe
    g3_entry = 1'b1; boot_cpl = 1'b1; boot_img_ok = 1'b1;
    expect_at(1, 5'b00000, "R10");
    step(1);
    g3_entry = 1'b0; boot_cpl = 1'b0;
    expect_at(2, 5'b00000, "R10");
    step(4);
    finish_run();
  end
endmodule